// File: doc/BRIEF.md
# Wavefront Alignment Cell Array

This block is a square tile of dynamic-programming cells for scoring the alignment of two character strings. A tile is K cells by K cells. Each cell takes the value of its left neighbour, its upper neighbour and its upper-left neighbour. It forms both the smallest and the largest of those three values. A one-bit lookup, indexed by the pair of characters that meet at that cell, then picks which of the two the cell keeps. The characters for the columns arrive as one horizontal vector and the characters for the rows as one vertical vector. The values just above the tile, just to its left and at its upper-left corner arrive as boundary inputs.

The whole tile is unrolled in hardware and pipelined along its anti-diagonals. A new tile can be presented on every clock. Its bottom row and right column come out together 2K-1 cycles later, marked by a valid flag. A host aligns long strings by cutting them into chunks of K characters. The bottom row of one pass becomes the top boundary of the pass below it, and the right column becomes the left boundary of the pass to its right. The character width is a parameter: 2 bits suits nucleotides and 5 bits suits amino acids.

Top module: `wf_array`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and both `bottom_out` and `right_out` are all zeros.
- R2: Every cell value equals one of its three neighbour values, either the smallest or the largest of them.
- R3: Cell (i,j) builds the index {row character i, column character j}, with the row character in the upper bits. Bit number index of `SEL_TABLE` picks the result: 1 picks the largest neighbour and 0 picks the smallest.
- R4: Cell (i,j) uses cells (i,j-1), (i-1,j-1) and (i-1,j) as its neighbours. Row -1 is `top_bnd`, column -1 is `left_bnd`, and the position (-1,-1) is `corner_bnd`. So cell (0,j) takes top element j-1 as its upper-left neighbour when j>0, and cell (i,0) takes left element i-1 as its upper-left neighbour when i>0.
- R5: Values are compared as unsigned numbers, so 8'hF0 counts as larger than 8'h10.
- R6: A tile captured on a rising edge gives its results, with `out_valid` high, right after the 2K-1'th rising edge counted from and including the capture edge.
- R7: Tiles presented on consecutive cycles give results on consecutive cycles, in the same order and without mixing.
- R8: `out_valid` is 0 in every cycle that does not correspond to a cycle where `in_valid` was 1.
- R9: Vector element n sits at bits [n*SW +: SW] of each value port. `bottom_out` element j is cell (K-1,j) and `right_out` element i is cell (i,K-1).
- R10: Element j of `h_chars` (bits [j*CW +: CW]) is the character of column j. Element i of `v_chars` is the character of row i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A tile is presented this cycle |
| h_chars | input | K*CW | Column characters, element j for column j |
| v_chars | input | K*CW | Row characters, element i for row i |
| top_bnd | input | K*SW | Values of row -1, element j for column j |
| left_bnd | input | K*SW | Values of column -1, element i for row i |
| corner_bnd | input | SW | Value at position (-1,-1) |
| bottom_out | output | K*SW | Values of row K-1 |
| right_out | output | K*SW | Values of column K-1 |
| out_valid | output | 1 | The outputs belong to a presented tile |

## Verification
One wrong min/max choice, or a neighbour taken from the wrong cycle, in cell (i,j) spreads down and to the right through the wavefront. It reaches the bottom row or the right column, which the bench compares in full against a model for every tile. It shows there exactly 2K-1 cycles after that tile was captured. A misaligned delay stage shows differently. It mixes values from back-to-back tiles, and the streaming test catches that. A valid pipeline of the wrong length shows as `out_valid` arriving one cycle early or late against the expected cycle.

// File: rtl/wf_pkg.sv
package wf_pkg;

    localparam int CW_NUCLEOTIDE = 2;
    localparam int CW_AMINO      = 5;

    typedef enum logic {
        PICK_MIN = 1'b0,
        PICK_MAX = 1'b1
    } pick_e;

    function automatic pick_e pick_from_bit(input logic b);
        return b ? PICK_MAX : PICK_MIN;
    endfunction

endpackage

// File: rtl/wf_delay.sv
module wf_delay #(
    parameter int W = 8,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (D == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg [D];
            logic         live_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < D; k++) stg[k] <= '0;
                    live_q <= 1'b0;
                end else begin
                    stg[0] <= d;
                    for (int k = 1; k < D; k++) stg[k] <= stg[k-1];
                    live_q <= 1'b1;
                end
            end

            assign q = stg[D-1];

            // R7: each stage holds exactly the previous cycle's input
            a_r7_stage_follows: assert property (@(posedge clk) disable iff (rst)
                live_q |-> stg[0] == $past(d));
        end
    endgenerate
endmodule

// File: rtl/wf_cell.sv
module wf_cell
    import wf_pkg::*;
#(
    parameter int CW = 2,
    parameter int SW = 8,
    parameter logic [(1<<(2*CW))-1:0] TABLE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] left_i,
    input  logic [SW-1:0] up_i,
    input  logic [SW-1:0] diag_i,
    input  logic [CW-1:0] hch_i,
    input  logic [CW-1:0] vch_i,
    output logic [SW-1:0] value_o,
    output logic [SW-1:0] left_o,
    output logic [CW-1:0] hch_o,
    output logic [CW-1:0] vch_o
);
    localparam int IDXW = 2 * CW;

    logic [SW-1:0]   lo, hi, nxt;
    logic [IDXW-1:0] idx;
    pick_e           pick;
    logic            live_q;

    always_comb begin
        lo = left_i;
        if (up_i   < lo) lo = up_i;
        if (diag_i < lo) lo = diag_i;
        hi = left_i;
        if (up_i   > hi) hi = up_i;
        if (diag_i > hi) hi = diag_i;
        idx  = {vch_i, hch_i};
        pick = pick_from_bit(TABLE[idx]);
        nxt  = (pick == PICK_MAX) ? hi : lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value_o <= '0;
            left_o  <= '0;
            hch_o   <= '0;
            vch_o   <= '0;
            live_q  <= 1'b0;
        end else begin
            value_o <= nxt;
            left_o  <= left_i;
            hch_o   <= hch_i;
            vch_o   <= vch_i;
            live_q  <= 1'b1;
        end
    end

    // R2: result is one of the three neighbours seen one cycle earlier
    a_r2_is_neighbour: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (value_o == $past(left_i) || value_o == $past(up_i) ||
                    value_o == $past(diag_i)));

    // R3: a max pick is not below any neighbour
    a_r3_max_pick: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(pick) == PICK_MAX) |->
            (value_o >= $past(left_i) && value_o >= $past(up_i) &&
             value_o >= $past(diag_i)));

    // R3: a min pick is not above any neighbour
    a_r3_min_pick: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(pick) == PICK_MIN) |->
            (value_o <= $past(left_i) && value_o <= $past(up_i) &&
             value_o <= $past(diag_i)));

    // R10: characters travel one cell per cycle unchanged
    a_r10_char_travel: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (hch_o == $past(hch_i) && vch_o == $past(vch_i)));
endmodule

// File: rtl/wf_array.sv
module wf_array
    import wf_pkg::*;
#(
    parameter int K  = 4,
    parameter int CW = CW_NUCLEOTIDE,
    parameter int SW = 8,
    parameter logic [(1<<(2*CW))-1:0] SEL_TABLE = {((1<<(2*CW))/16){16'h6A93}}
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [K*CW-1:0] h_chars,
    input  logic [K*CW-1:0] v_chars,
    input  logic [K*SW-1:0] top_bnd,
    input  logic [K*SW-1:0] left_bnd,
    input  logic [SW-1:0]   corner_bnd,
    output logic [K*SW-1:0] bottom_out,
    output logic [K*SW-1:0] right_out,
    output logic            out_valid
);
    localparam int LAT = 2 * K - 1;

    logic [SW-1:0] val  [K][K];
    logic [SW-1:0] lft  [K][K];
    logic [CW-1:0] hc   [K][K];
    logic [CW-1:0] vc   [K][K];

    logic [SW-1:0] top_d   [K];
    logic [SW-1:0] tdiag_d [K];
    logic [SW-1:0] left_d  [K];
    logic [CW-1:0] hch_d   [K];
    logic [CW-1:0] vch_d   [K];

    genvar b, gi, gj;

    // boundary skew: element b enters the wavefront b cycles late
    generate
        for (b = 0; b < K; b++) begin : g_bnd
            wf_delay #(.W(SW), .D(b)) u_top (.clk(clk), .rst(rst),
                .d(top_bnd[b*SW +: SW]), .q(top_d[b]));
            wf_delay #(.W(SW), .D(b)) u_left (.clk(clk), .rst(rst),
                .d(left_bnd[b*SW +: SW]), .q(left_d[b]));
            wf_delay #(.W(CW), .D(b)) u_hch (.clk(clk), .rst(rst),
                .d(h_chars[b*CW +: CW]), .q(hch_d[b]));
            wf_delay #(.W(CW), .D(b)) u_vch (.clk(clk), .rst(rst),
                .d(v_chars[b*CW +: CW]), .q(vch_d[b]));
            if (b == 0) begin : g_corner
                assign tdiag_d[b] = corner_bnd;
            end else begin : g_tdiag
                wf_delay #(.W(SW), .D(b)) u_tdiag (.clk(clk), .rst(rst),
                    .d(top_bnd[(b-1)*SW +: SW]), .q(tdiag_d[b]));
            end
        end
    endgenerate

    // the unrolled tile
    generate
        for (gi = 0; gi < K; gi++) begin : g_row
            for (gj = 0; gj < K; gj++) begin : g_col
                logic [SW-1:0] c_left, c_up, c_diag;
                logic [CW-1:0] c_h, c_v;
                if (gi == 0) begin : g_top
                    assign c_up   = top_d[gj];
                    assign c_diag = tdiag_d[gj];
                    assign c_h    = hch_d[gj];
                end else begin : g_inner_up
                    assign c_up   = val[gi-1][gj];
                    assign c_diag = lft[gi-1][gj];
                    assign c_h    = hc[gi-1][gj];
                end
                if (gj == 0) begin : g_lcol
                    assign c_left = left_d[gi];
                    assign c_v    = vch_d[gi];
                end else begin : g_inner_left
                    assign c_left = val[gi][gj-1];
                    assign c_v    = vc[gi][gj-1];
                end
                wf_cell #(.CW(CW), .SW(SW), .TABLE(SEL_TABLE)) u_cell (
                    .clk(clk), .rst(rst),
                    .left_i(c_left), .up_i(c_up), .diag_i(c_diag),
                    .hch_i(c_h), .vch_i(c_v),
                    .value_o(val[gi][gj]), .left_o(lft[gi][gj]),
                    .hch_o(hc[gi][gj]), .vch_o(vc[gi][gj]));
            end
        end
    endgenerate

    // de-skew edges so the whole tile leaves together
    generate
        for (b = 0; b < K; b++) begin : g_out
            wf_delay #(.W(SW), .D(K-1-b)) u_bot (.clk(clk), .rst(rst),
                .d(val[K-1][b]), .q(bottom_out[b*SW +: SW]));
            wf_delay #(.W(SW), .D(K-1-b)) u_rgt (.clk(clk), .rst(rst),
                .d(val[b][K-1]), .q(right_out[b*SW +: SW]));
        end
    endgenerate

    wf_delay #(.W(1), .D(LAT)) u_valid (.clk(clk), .rst(rst),
        .d(in_valid), .q(out_valid));
endmodule

// File: tb/wf_array_tb.sv
module wf_array_tb_top;
    localparam int K   = 4;
    localparam int CW  = 2;
    localparam int SW  = 8;
    localparam int LAT = 2 * K - 1;
    localparam logic [15:0] TBL = 16'h6A93;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [K*CW-1:0] h_chars = '0, v_chars = '0;
    logic [K*SW-1:0] top_bnd = '0, left_bnd = '0;
    logic [SW-1:0]   corner_bnd = '0;
    logic [K*SW-1:0] bottom_out, right_out;
    logic            out_valid;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R4";

    logic [K*SW-1:0] q_bot [$];
    logic [K*SW-1:0] q_rgt [$];
    int              q_due [$];

    wf_array #(.K(K), .CW(CW), .SW(SW), .SEL_TABLE(TBL)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .h_chars(h_chars), .v_chars(v_chars),
        .top_bnd(top_bnd), .left_bnd(left_bnd), .corner_bnd(corner_bnd),
        .bottom_out(bottom_out), .right_out(right_out), .out_valid(out_valid));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model: a[0][*] is row -1, a[*][0] is column -1
    task automatic model(input logic [K*CW-1:0] h, input logic [K*CW-1:0] v,
                         input logic [K*SW-1:0] t, input logic [K*SW-1:0] l,
                         input logic [SW-1:0] c,
                         output logic [K*SW-1:0] bo, output logic [K*SW-1:0] ro);
        int a [K+1][K+1];
        a[0][0] = int'(c);
        for (int j = 0; j < K; j++) a[0][j+1] = int'(t[j*SW +: SW]);
        for (int i = 0; i < K; i++) a[i+1][0] = int'(l[i*SW +: SW]);
        for (int i = 0; i < K; i++)
            for (int j = 0; j < K; j++) begin
                int x, y, z, mn, mx, idx;
                x = a[i+1][j]; y = a[i][j]; z = a[i][j+1];
                mn = x; if (y < mn) mn = y; if (z < mn) mn = z;
                mx = x; if (y > mx) mx = y; if (z > mx) mx = z;
                idx = int'(v[i*CW +: CW]) * (1 << CW) + int'(h[j*CW +: CW]);
                a[i+1][j+1] = TBL[idx] ? mx : mn;
            end
        for (int j = 0; j < K; j++) bo[j*SW +: SW] = SW'(a[K][j+1]);
        for (int i = 0; i < K; i++) ro[i*SW +: SW] = SW'(a[i+1][K]);
    endtask

    // one cycle: move to the falling edge and compare whatever is due
    task automatic step();
        @(negedge clk);
        if (out_valid) begin
            if (q_due.size() == 0) begin
                check(1'b0, "R8", "unexpected out_valid", 64'd1, 64'd0);
            end else begin
                int due;
                logic [K*SW-1:0] eb, er;
                due = q_due.pop_front(); eb = q_bot.pop_front(); er = q_rgt.pop_front();
                check(due == cyc, "R6", "result cycle", 64'(cyc), 64'(due));
                check(bottom_out == eb, cur_req, "bottom_out", 64'(bottom_out), 64'(eb));
                check(right_out == er, cur_req, "right_out", 64'(right_out), 64'(er));
            end
        end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
            check(1'b0, "R6", "missing out_valid", 64'd0, 64'd1);
            void'(q_due.pop_front()); void'(q_bot.pop_front()); void'(q_rgt.pop_front());
        end
    endtask

    task automatic drive(input logic [K*CW-1:0] h, input logic [K*CW-1:0] v,
                         input logic [K*SW-1:0] t, input logic [K*SW-1:0] l,
                         input logic [SW-1:0] c);
        logic [K*SW-1:0] bo, ro;
        model(h, v, t, l, c, bo, ro);
        h_chars = h; v_chars = v; top_bnd = t; left_bnd = l; corner_bnd = c;
        in_valid = 1'b1;
        q_bot.push_back(bo); q_rgt.push_back(ro); q_due.push_back(cyc + LAT);
    endtask

    task automatic idle();
        in_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        for (int n = 0; n < LAT + 2; n++) step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        check(bottom_out == '0, "R1", "bottom_out in reset", 64'(bottom_out), 64'd0);
        check(right_out == '0, "R1", "right_out in reset", 64'(right_out), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && right_out == '0, "R1", "first cycle after reset",
              64'(out_valid), 64'd0);
    endtask

    // single tile, latency and packing
    task automatic t_single();
        cur_req = "R4 R9";
        drive(8'b11_10_01_00, 8'b00_01_10_11, 32'h40302010, 32'h05152535, 8'h22);
        step();
        idle();
        for (int n = 0; n < LAT - 2; n++) begin
            step();
            check(out_valid == 1'b0, "R6", "early out_valid", 64'(out_valid), 64'd0);
        end
        drain();
    endtask

    // every (row,column) character pair once; distinct boundaries
    task automatic t_table();
        cur_req = "R3 R10";
        drive(8'b11_10_01_00, 8'b11_10_01_00, 32'h11335577, 32'h2244668A, 8'h99);
        step();
        drive(8'b00_01_10_11, 8'b10_11_00_01, 32'h0A1B2C3D, 32'h4E5F6071, 8'h82);
        step();
        drain();
    endtask

    // values above and below half range
    task automatic t_unsigned();
        cur_req = "R5";
        drive(8'b01_01_01_01, 8'b10_00_11_01, 32'hF010F010, 32'h10F010F0, 8'h80);
        step();
        drain();
    endtask

    // tiles back to back
    task automatic t_stream();
        cur_req = "R7";
        for (int n = 0; n < 6; n++) begin
            drive(K*CW'($urandom), K*CW'($urandom), K*SW'($urandom),
                  K*SW'($urandom), SW'($urandom));
            step();
        end
        drain();
    endtask

    // gap between tiles must leave out_valid low
    task automatic t_gap();
        cur_req = "R8";
        drive(8'h1B, 8'hE4, 32'h01020304, 32'h0A0B0C0D, 8'h07);
        step();
        idle();
        step(); step();
        drive(8'h72, 8'h8D, 32'hFFEEDDCC, 32'h00112233, 8'h55);
        step();
        idle();
        for (int n = 0; n < LAT + 2; n++) begin
            step();
            if (q_due.size() == 0) continue;
            if (cyc < q_due[0] && cyc > q_due[0] - 3) begin
                check(out_valid == 1'b0, "R8", "out_valid in gap", 64'(out_valid), 64'd0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_table();
        t_unsigned();
        t_stream();
        t_gap();
        check(q_due.size() == 0, "R7", "results outstanding", 64'(q_due.size()), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule